// File: doc/BRIEF.md
# Hot-Plug and Sink Capability Manager

This block runs on the source side of a digital display link. It watches the debounced hot-plug level from the sink. When that level goes high, it fetches the sink's identification data one byte at a time through a request/acknowledge port. That port stands in for the display data channel master, so each byte may take a long and variable number of cycles. The block reads the 128-byte base block. When the base block announces at least one extension, it also reads the first extension. As the bytes stream past, it walks the extension's data-block collection and looks for the vendor block that marks an HDMI-capable sink. A sink without that block is treated as a DVI sink.

The results are held in registers and exposed as four flags:
- a link-allowed flag;
- an HDMI-mode flag;
- a fallback flag, meaning only the universal 640x480 progressive format should be driven;
- the +5V enable.

A read error or a response timeout puts the link into safe DVI/fallback operation and schedules a fresh read. A brief low pulse on hot-plug means the sink's data changed, so the block drops its result and reads again. A long low period is a disconnect.

Top module: `hpd_cap_mgr`

## Requirements
- R1: After reset every output is low and no byte is requested while `hpd_i` is low. The cycle after `hpd_i` is sampled high, `rd_req_o` is high with `rd_addr_o` = 0.
- R2: While `rd_req_o` is high, `rd_addr_o` holds steady until `rd_ack_i` or `rd_err_i` is sampled. An acknowledge takes `rd_data_i` as the byte at `rd_addr_o`, and the next request is for the next address.
- R3: Byte 126 holds the extension count. If it is zero, the read ends after byte 127. Otherwise the read ends after byte 255.
- R4: The sink is HDMI only when all of the following hold:
  - byte 128 equals 0x02;
  - the data-block collection, which starts at extension offset 4 and ends before the offset given in byte 130, holds a block header whose tag field (bits 7:5) is 3 and whose length field (bits 4:0) is at least 3;
  - that header is followed by the bytes 0x03, 0x0C, 0x00.
- R5: A completed read without that vendor block leaves `link_ok_o`=1, `hdmi_mode_o`=0 and `fallback_o`=0. These flags update in the cycle after the last acknowledge.
- R6: `pwr5v_o` is high exactly when a byte is being requested or the link is allowed.
- R7: A sampled `rd_err_i` during a read sets `link_ok_o`=1, `hdmi_mode_o`=0 and `fallback_o`=1 on the next cycle. After `RETRY_CYC` cycles a new read starts from address 0, and these flags stay unchanged until that read completes.
- R8: `TMO_CYC` consecutive request cycles without a response are handled exactly like a read error.
- R9: A low period on `hpd_i` shorter than the disconnect threshold leaves the flags unchanged while low. When `hpd_i` returns high, the flags clear and a new read starts at address 0.
- R10: Once `hpd_i` has been sampled low for `DISC_CYC`+1 consecutive cycles, all outputs go low and the block waits for `hpd_i` to rise.
- R11: If `hpd_i` is sampled low during a read, `rd_req_o` is low on the next cycle.
- R12: `fallback_o` is only ever high together with `link_ok_o` and never together with `hdmi_mode_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hpd_i | input | 1 | Debounced hot-plug level from the sink |
| rd_req_o | output | 1 | Byte request outstanding |
| rd_addr_o | output | 8 | Byte offset being requested (0..255) |
| rd_data_i | input | 8 | Byte returned with the acknowledge |
| rd_ack_i | input | 1 | Byte delivered this cycle |
| rd_err_i | input | 1 | Current request failed |
| pwr5v_o | output | 1 | +5V supply enable toward the sink |
| link_ok_o | output | 1 | Video link may be driven |
| hdmi_mode_o | output | 1 | Sink classified as HDMI |
| fallback_o | output | 1 | Restrict output to 640x480 progressive |

## Verification
The bench builds the block with `DISC_CYC`=40, `TMO_CYC`=16 and `RETRY_CYC`=30. With those values, the disconnect threshold, the response timeout and the retry delay each occur within a few dozen cycles. This lets one run cover a short change pulse as well as a full disconnect, an erroring and a stalled responder, and the retried read that follows each of them. Sink images are varied in the following ways:
- the extension count;
- the extension tag;
- the collection end offset, placed exactly at the vendor block and one past it;
- the vendor identifier bytes.

The responder latency is also varied, so the address-hold rule is exercised across a range of response delays.

// File: rtl/hpcm_pkg.sv
package hpcm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,   // no sink, waiting for hot-plug
    ST_FETCH,  // streaming identification bytes
    ST_UP,     // result valid, link running
    ST_LOW,    // hot-plug low, deciding pulse vs disconnect
    ST_SAFE    // failed read, fallback link, waiting to retry
  } hp_state_t;

  localparam logic [7:0] OFS_EXTCNT = 8'd126;
  localparam logic [7:0] OFS_BASEND = 8'd127;
  localparam logic [7:0] OFS_EXTTAG = 8'd128;
  localparam logic [7:0] OFS_DLIM   = 8'd130;
  localparam logic [7:0] OFS_EXTEND = 8'd255;
  localparam logic [7:0] FIRST_BLK  = 8'd4;
  localparam logic [7:0] EXT_TAG    = 8'h02;
  localparam logic [2:0] VS_TAG     = 3'd3;

  // vendor identifier, least significant byte first
  function automatic logic [7:0] vs_id(input logic [1:0] idx);
    case (idx)
      2'd0:    vs_id = 8'h03;
      2'd1:    vs_id = 8'h0C;
      default: vs_id = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/hpcm_timer.sv
module hpcm_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic hit
);
  localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT);

  logic [W-1:0] cnt;

  assign hit = en && (cnt == W'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || clr)       cnt <= '0;
    else if (en && !hit)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/hpcm_cea_scan.sv
module hpcm_cea_scan
  import hpcm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clr_i,
  input  logic       vld_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] data_i,
  output logic       noext_o,
  output logic       hdmi_nx_o
);
  logic       noext, tag_ok, cand, hit;
  logic [7:0] dlim, nxt;
  logic [1:0] idx;
  logic       noext_n, tag_ok_n, cand_n, hit_n;
  logic [7:0] dlim_n, nxt_n, off;
  logic [1:0] idx_n;

  always_comb begin
    noext_n  = noext;
    tag_ok_n = tag_ok;
    dlim_n   = dlim;
    nxt_n    = nxt;
    cand_n   = cand;
    idx_n    = idx;
    hit_n    = hit;
    off      = {1'b0, addr_i[6:0]};
    if (vld_i) begin
      if (addr_i == OFS_EXTCNT) noext_n = (data_i == 8'd0);
      if (addr_i == OFS_EXTTAG) tag_ok_n = (data_i == EXT_TAG);
      if (addr_i == OFS_DLIM) begin
        dlim_n = data_i;
        nxt_n  = FIRST_BLK;
      end
      if (addr_i[7]) begin
        if ((off == nxt) && (off < dlim)) begin
          // block header: tag in 7:5, payload length in 4:0
          nxt_n  = off + {3'b000, data_i[4:0]} + 8'd1;
          cand_n = (data_i[7:5] == VS_TAG) && (data_i[4:0] >= 5'd3);
          idx_n  = 2'd0;
        end else if (cand) begin
          if (data_i == vs_id(idx)) begin
            idx_n = idx + 2'd1;
            if (idx == 2'd2) begin
              hit_n  = 1'b1;
              cand_n = 1'b0;
            end
          end else begin
            cand_n = 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      noext  <= 1'b0;
      tag_ok <= 1'b0;
      dlim   <= 8'd0;
      nxt    <= 8'hFF;
      cand   <= 1'b0;
      idx    <= 2'd0;
      hit    <= 1'b0;
    end else begin
      noext  <= noext_n;
      tag_ok <= tag_ok_n;
      dlim   <= dlim_n;
      nxt    <= nxt_n;
      cand   <= cand_n;
      idx    <= idx_n;
      hit    <= hit_n;
    end
  end

  assign noext_o   = noext;
  assign hdmi_nx_o = hit_n && tag_ok && !noext;
endmodule

// File: rtl/hpd_cap_mgr.sv
module hpd_cap_mgr
  import hpcm_pkg::*;
#(
  parameter int DISC_CYC  = 10_000_000,
  parameter int TMO_CYC   = 20_000,
  parameter int RETRY_CYC = 5_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       hpd_i,
  output logic       rd_req_o,
  output logic [7:0] rd_addr_o,
  input  logic [7:0] rd_data_i,
  input  logic       rd_ack_i,
  input  logic       rd_err_i,
  output logic       pwr5v_o,
  output logic       link_ok_o,
  output logic       hdmi_mode_o,
  output logic       fallback_o
);
  hp_state_t  st;
  logic [7:0] addr_q;
  logic       link_q, hdmi_q, fb_q;
  logic       fetching, got, fail, last, start;
  logic       tmo_hit, low_hit, rty_hit, noext, hdmi_nx;

  assign fetching = (st == ST_FETCH);
  assign got   = fetching && hpd_i && rd_ack_i && !rd_err_i;
  assign fail  = fetching && hpd_i && (rd_err_i || (tmo_hit && !rd_ack_i));
  assign last  = got && ((addr_q == OFS_EXTEND) || ((addr_q == OFS_BASEND) && noext));
  assign start = hpd_i && ((st == ST_IDLE) || (st == ST_LOW) || ((st == ST_SAFE) && rty_hit));

  hpcm_timer #(.LIMIT(TMO_CYC)) u_tmo (
    .clk(clk), .rst(rst),
    .clr(!fetching || rd_ack_i || rd_err_i),
    .en(fetching), .hit(tmo_hit)
  );

  hpcm_timer #(.LIMIT(DISC_CYC)) u_low (
    .clk(clk), .rst(rst),
    .clr(st != ST_LOW),
    .en((st == ST_LOW) && !hpd_i), .hit(low_hit)
  );

  hpcm_timer #(.LIMIT(RETRY_CYC)) u_rty (
    .clk(clk), .rst(rst),
    .clr(st != ST_SAFE),
    .en(st == ST_SAFE), .hit(rty_hit)
  );

  hpcm_cea_scan u_scan (
    .clk(clk), .rst(rst), .clr_i(start), .vld_i(got),
    .addr_i(addr_q), .data_i(rd_data_i),
    .noext_o(noext), .hdmi_nx_o(hdmi_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      addr_q <= 8'd0;
      link_q <= 1'b0;
      hdmi_q <= 1'b0;
      fb_q   <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (hpd_i) begin
          st     <= ST_FETCH;
          addr_q <= 8'd0;
        end
        ST_FETCH: begin
          if (!hpd_i) st <= ST_LOW;
          else if (fail) begin
            st     <= ST_SAFE;
            link_q <= 1'b1;
            hdmi_q <= 1'b0;
            fb_q   <= 1'b1;
          end else if (last) begin
            st     <= ST_UP;
            link_q <= 1'b1;
            hdmi_q <= hdmi_nx;
            fb_q   <= 1'b0;
          end else if (got) addr_q <= addr_q + 8'd1;
        end
        ST_UP: if (!hpd_i) st <= ST_LOW;
        ST_SAFE: begin
          if (!hpd_i) st <= ST_LOW;
          else if (rty_hit) begin
            st     <= ST_FETCH;
            addr_q <= 8'd0;
          end
        end
        ST_LOW: begin
          if (hpd_i || low_hit) begin
            st     <= hpd_i ? ST_FETCH : ST_IDLE;
            addr_q <= 8'd0;
            link_q <= 1'b0;
            hdmi_q <= 1'b0;
            fb_q   <= 1'b0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign rd_req_o    = fetching;
  assign rd_addr_o   = addr_q;
  assign pwr5v_o     = fetching || link_q;
  assign link_ok_o   = link_q;
  assign hdmi_mode_o = hdmi_q;
  assign fallback_o  = fb_q;
endmodule

// File: rtl/hpd_cap_mgr_chk.sv
module hpd_cap_mgr_chk (
  input logic       clk,
  input logic       rst,
  input logic       hpd_i,
  input logic       rd_ack_i,
  input logic       rd_err_i,
  input logic       rd_req_o,
  input logic [7:0] rd_addr_o,
  input logic       link_ok_o,
  input logic       hdmi_mode_o,
  input logic       fallback_o
);
  a_r2_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (rd_req_o && !rd_ack_i && !rd_err_i) |=> (!rd_req_o || $stable(rd_addr_o)));

  a_r11_drop_req: assert property (@(posedge clk) disable iff (rst)
    (rd_req_o && !hpd_i) |=> !rd_req_o);

  a_r12_fb_excl: assert property (@(posedge clk) disable iff (rst)
    fallback_o |-> (link_ok_o && !hdmi_mode_o));

  a_r1_req_after_hpd: assert property (@(posedge clk) disable iff (rst)
    rd_req_o |-> $past(hpd_i));

  a_r4_hdmi_from_read: assert property (@(posedge clk) disable iff (rst)
    $rose(hdmi_mode_o) |-> ($past(rd_req_o) && $past(rd_ack_i)));
endmodule

bind hpd_cap_mgr hpd_cap_mgr_chk u_chk (
  .clk(clk), .rst(rst), .hpd_i(hpd_i), .rd_ack_i(rd_ack_i), .rd_err_i(rd_err_i),
  .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .link_ok_o(link_ok_o),
  .hdmi_mode_o(hdmi_mode_o), .fallback_o(fallback_o)
);

// File: tb/tb_hpd_cap_mgr.sv
module tb_hpd_cap_mgr;
  localparam int CLK_PERIOD = 10;
  localparam int DISC  = 40;
  localparam int TMO   = 16;
  localparam int RETRY = 30;

  logic clk = 1'b0, rst = 1'b1, hpd = 1'b0, ack = 1'b0, err = 1'b0;
  logic [7:0] rdata = 8'd0;
  logic req, pwr, link, hdmi, fb;
  logic [7:0] addr;

  hpd_cap_mgr #(.DISC_CYC(DISC), .TMO_CYC(TMO), .RETRY_CYC(RETRY)) dut (
    .clk(clk), .rst(rst), .hpd_i(hpd), .rd_req_o(req), .rd_addr_o(addr),
    .rd_data_i(rdata), .rd_ack_i(ack), .rd_err_i(err), .pwr5v_o(pwr),
    .link_ok_o(link), .hdmi_mode_o(hdmi), .fallback_o(fb)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  logic [7:0] mem [256];
  logic [7:0] cap [256];

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // ---------------- responder ----------------
  int lat = 1, rcnt = 0, err_addr = -1, max_addr = -1;
  bit stall = 0;
  always @(negedge clk) begin
    if (req && int'(addr) > max_addr) max_addr = int'(addr);
    if (ack || err) begin
      ack = 0; err = 0; rcnt = 0;
    end else if (!req || stall || rst) rcnt = 0;
    else if (rcnt >= lat) begin
      if (int'(addr) == err_addr) begin err = 1; err_addr = -1; end
      else begin ack = 1; rdata = mem[addr]; end
    end else rcnt++;
  end

  // ---------------- reference model ----------------
  int mst = 0, maddr = 0, mwait = 0, mlow = 0, mretry = 0;
  bit ml = 0, mh = 0, mf = 0, started = 0;

  function automatic bit classify();
    int p, d, tg, ln;
    bit f = 0;
    if (cap[126] == 8'd0 || cap[128] != 8'h02) return 0;
    d = int'(cap[130]);
    p = 4;
    while (p < d && p < 128) begin
      tg = int'(cap[128+p][7:5]);
      ln = int'(cap[128+p][4:0]);
      if (tg == 3 && ln >= 3 && p + 3 <= 127 && cap[129+p] == 8'h03 &&
          cap[130+p] == 8'h0C && cap[131+p] == 8'h00) f = 1;
      p = p + ln + 1;
    end
    return f;
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      mst = 0; maddr = 0; mwait = 0; mlow = 0; mretry = 0; ml = 0; mh = 0; mf = 0;
    end else begin
      case (mst)
        0: if (hpd) begin mst = 1; maddr = 0; mwait = 0; end
        1: begin
          if (!hpd) begin mst = 3; mlow = 0; end
          else if (err || (mwait == TMO - 1 && !ack)) begin
            mst = 4; mretry = 0; ml = 1; mh = 0; mf = 1;
          end else if (ack) begin
            cap[maddr] = rdata;
            if (maddr == 255 || (maddr == 127 && cap[126] == 8'd0)) begin
              mst = 2; ml = 1; mh = classify(); mf = 0;
            end else begin maddr++; mwait = 0; end
          end else mwait++;
        end
        2: if (!hpd) begin mst = 3; mlow = 0; end
        4: begin
          if (!hpd) begin mst = 3; mlow = 0; end
          else if (mretry == RETRY - 1) begin mst = 1; maddr = 0; mwait = 0; end
          else mretry++;
        end
        default: begin
          if (hpd) begin mst = 1; maddr = 0; mwait = 0; ml = 0; mh = 0; mf = 0; end
          else if (mlow == DISC - 1) begin mst = 0; ml = 0; mh = 0; mf = 0; end
          else mlow++;
        end
      endcase
    end
  end

  // per-clock comparison
  always @(negedge clk) begin
    if (started) begin
      chk("R2 req", int'(req), int'(mst == 1));
      if (mst == 1) chk("R2 addr", int'(addr), maddr);
      chk("R5 link", int'(link), int'(ml));
      chk("R4 hdmi", int'(hdmi), int'(mh));
      chk("R7 fallback", int'(fb), int'(mf));
      chk("R6 pwr", int'(pwr), int'((mst == 1) || ml));
    end
  end

  // watchdog
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- images ----------------
  task automatic img_hdmi();
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 1);
    mem[126] = 8'd1;
    mem[128] = 8'h02; mem[129] = 8'h03; mem[130] = 8'd20; mem[131] = 8'h00;
    mem[132] = {3'd2, 5'd3}; mem[133] = 8'h10; mem[134] = 8'h04; mem[135] = 8'h03;
    mem[136] = {3'd3, 5'd5}; mem[137] = 8'h03; mem[138] = 8'h0C; mem[139] = 8'h00;
    mem[140] = 8'h10; mem[141] = 8'h00;
    mem[142] = {3'd1, 5'd3}; mem[143] = 8'h09; mem[144] = 8'h07; mem[145] = 8'h07;
  endtask

  task automatic wait_state(input int s, input string tag);
    int n = 0;
    do begin @(negedge clk); n++; end while (mst != s && n < 5000);
    chk(tag, mst, s);
  endtask

  task automatic pulse_read(input string tag);
    hpd = 0;
    repeat (5) @(negedge clk);
    max_addr = -1;
    hpd = 1;
    wait_state(2, tag);
  endtask

  initial begin
    img_hdmi();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 link", int'(link), 0); chk("R1 hdmi", int'(hdmi), 0);
    chk("R1 fb", int'(fb), 0); chk("R1 pwr", int'(pwr), 0);
    repeat (5) @(negedge clk);
    chk("R1 no req while low", int'(req), 0);

    // HDMI sink
    lat = 3; max_addr = -1;
    hpd = 1;
    @(negedge clk);
    chk("R1 req", int'(req), 1); chk("R1 addr0", int'(addr), 0);
    wait_state(2, "R4 done");
    chk("R4 hdmi", int'(hdmi), 1); chk("R4 link", int'(link), 1);
    chk("R6 pwr", int'(pwr), 1); chk("R3 read to 255", max_addr, 255);

    // DVI sink after a short change pulse
    mem[139] = 8'h01; lat = 0;
    hpd = 0;
    repeat (5) @(negedge clk);
    chk("R9 held link", int'(link), 1); chk("R9 held hdmi", int'(hdmi), 1);
    hpd = 1;
    @(negedge clk);
    chk("R9 cleared", int'(link), 0); chk("R9 restart addr", int'(addr), 0);
    wait_state(2, "R5 done");
    chk("R5 hdmi", int'(hdmi), 0); chk("R5 link", int'(link), 1); chk("R5 fb", int'(fb), 0);

    // no extension announced
    img_hdmi(); mem[126] = 8'd0; lat = 1;
    pulse_read("R3 done");
    chk("R3 stop at 127", max_addr, 127); chk("R3 hdmi", int'(hdmi), 0);

    // wrong extension tag
    img_hdmi(); mem[128] = 8'h03;
    pulse_read("R4 tag done");
    chk("R4 tag", int'(hdmi), 0);

    // collection ends exactly at vendor block / one past it
    img_hdmi(); mem[130] = 8'd8;
    pulse_read("R4 lim done");
    chk("R4 beyond limit", int'(hdmi), 0);
    mem[130] = 8'd9;
    pulse_read("R4 lim9 done");
    chk("R4 inside limit", int'(hdmi), 1);

    // short vendor block
    img_hdmi(); mem[136] = {3'd3, 5'd2};
    pulse_read("R4 len done");
    chk("R4 short block", int'(hdmi), 0);

    // read error, then retry
    img_hdmi(); err_addr = 40; lat = 2;
    hpd = 0; repeat (5) @(negedge clk); hpd = 1;
    wait_state(4, "R7 safe");
    chk("R7 link", int'(link), 1); chk("R7 fb", int'(fb), 1); chk("R12 hdmi", int'(hdmi), 0);
    wait_state(1, "R7 retry");
    chk("R7 held fb", int'(fb), 1); chk("R7 held link", int'(link), 1);
    wait_state(2, "R7 done");
    chk("R7 hdmi", int'(hdmi), 1); chk("R7 fb clear", int'(fb), 0);

    // timeout
    stall = 1;
    hpd = 0; repeat (5) @(negedge clk); hpd = 1;
    wait_state(4, "R8 safe");
    chk("R8 fb", int'(fb), 1); chk("R8 link", int'(link), 1);
    stall = 0;
    wait_state(2, "R8 done");
    chk("R8 hdmi", int'(hdmi), 1);

    // disconnect
    hpd = 0;
    repeat (20) @(negedge clk);
    chk("R10 before threshold", int'(link), 1);
    repeat (30) @(negedge clk);
    chk("R10 link", int'(link), 0); chk("R10 pwr", int'(pwr), 0); chk("R10 hdmi", int'(hdmi), 0);

    // hot-plug drop mid-read
    hpd = 1;
    repeat (10) @(negedge clk);
    hpd = 0;
    @(negedge clk);
    chk("R11 req dropped", int'(req), 0);
    repeat (60) @(negedge clk);
    chk("R10 idle", int'(pwr), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule